// File: doc/BRIEF.md
# Floating-Point Pending-Exception Freeze Controller

This block sits beside an instruction issue stage and decides when a pending floating-point exception may hold issue back. It keeps six sticky exception flags and their mask bits. An exception counts as pending when any flag is set and its mask bit is clear. In legacy reporting mode (`ne_mode` = 0) a pending exception drives the active-low `err_n` pin, which outside logic routes to an interrupt request. Issue is not stopped at once. The stall is deferred and falls only on the next waiting floating-point instruction or WAIT instruction that is offered.

Once frozen, that instruction stays stalled until `irq_taken` reports that some interrupt was accepted. On the next retry it freezes again if the handler left the flags uncleared. Driving `ignerr_n` low in legacy mode lets waiting instructions through despite the error. In native mode (`ne_mode` = 1) the pin and the freeze are bypassed, and a one-cycle `exc_pulse` marks each waiting instruction that issues while an exception is pending.

The issue side is a valid/ready stream. An instruction issues in a cycle where `iss_valid` and `iss_ready` are both high. While `iss_ready` is low the issuer must hold `iss_valid` and `iss_cls` steady. `iss_ready` depends on the offered class in the same cycle. All other pins are plain level or pulse signals.

Top module: `fpx_freeze_ctrl`

## Requirements
- R1: `flags_q` holds sticky flags. The bit positions are invalid 0, denormal 1, divide-by-zero 2, overflow 3, underflow 4 and precision 5. A bit set in `exc_set` sets the flag at the next edge. `flag_clr` zeroes all flags at the next edge. A flag set in the same cycle as a clear survives.
- R2: A mask bit of 1 hides its flag. An exception is pending only if a flag bit is 1 where the mask bit is 0.
- R3: `err_n` is low exactly while an exception is pending and `ne_mode` is 0. It returns high once clearing or masking leaves nothing pending.
- R4: The instruction classes are encoded as non-FP 0, waiting FP 1, no-wait FP 2 and WAIT 3. Classes 0 and 2 are never stalled (`iss_ready` high), even while frozen or pending.
- R5: With `ne_mode` 0 and `ignerr_n` high, a valid class 1 or 3 instruction sees `iss_ready` low in the same cycle while an exception is pending. The block then enters the frozen state.
- R6: When frozen, class 1 and 3 instructions stay stalled even if the exception stops being pending. The stall lasts through the cycle in which `irq_taken` is high and is lifted after that edge.
- R7: After release, a retried waiting instruction stalls and freezes again if the flags are still pending. If they were cleared, it issues.
- R8: With `ne_mode` 0 and `ignerr_n` low, waiting instructions issue despite a pending exception, while `err_n` stays low.
- R9: With `ne_mode` 1 nothing is stalled and `err_n` stays high. In the cycle after a waiting instruction issues with an exception pending, `exc_pulse` is high for one cycle.
- R10: Reset clears the flags, the frozen state and `exc_pulse`, leaving `iss_ready` and `err_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_cls | input | 2 | Class of the offered instruction (R4 encoding) |
| iss_ready | output | 1 | Instruction may issue this cycle |
| exc_set | input | 6 | One-cycle flag set pulses |
| exc_mask | input | 6 | Mask bits, 1 hides the flag |
| ne_mode | input | 1 | 1 selects native internal reporting |
| ignerr_n | input | 1 | Active-low ignore-error request |
| irq_taken | input | 1 | An interrupt was accepted this cycle |
| flag_clr | input | 1 | Clear all exception flags |
| err_n | output | 1 | Active-low error pin |
| exc_pulse | output | 1 | One-cycle internal exception indication |
| flags_q | output | 6 | Current exception flags |

## Verification
Every cycle, the assertions check that non-waiting classes are never stalled, that a stall holds until an interrupt or an ignore request, that a clear with no new set empties the flags, that native mode never asserts the pin, and that each pulse follows a waiting instruction offered in native mode. The bench scenarios are needed to show the ordering effects: the deferred stall that lands only on the next waiting instruction, the stall persisting after masking, the retrigger after an interrupt when the handler did not clear, and the precedence of set over clear.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NFLAG = 6;

  typedef enum logic [1:0] {
    CLS_NONFP  = 2'd0,
    CLS_WAITFP = 2'd1,
    CLS_NOWAIT = 2'd2,
    CLS_WAIT   = 2'd3
  } iss_cls_e;

  function automatic logic cls_waits(input logic [1:0] c);
    return (c == CLS_WAITFP) || (c == CLS_WAIT);
  endfunction
endpackage

// File: rtl/fpx_flag_bank.sv
module fpx_flag_bank #(
  parameter int W = fpx_pkg::NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  output logic [W-1:0] flags_o,
  output logic         pending_o
);
  logic [W-1:0] flags_r;
  logic [W-1:0] live;

  // Sticky flags: clear first, then new sets are merged in.
  always_ff @(posedge clk) begin
    if (!rst_n) flags_r <= '0;
    else        flags_r <= (clr_i ? '0 : flags_r) | set_i;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_live
      assign live[i] = flags_r[i] & ~mask_i[i];
    end
  endgenerate

  assign flags_o   = flags_r;
  assign pending_o = |live;

  a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i == '0) |=> (flags_o == '0));
  a_r1_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/fpx_freeze_unit.sv
module fpx_freeze_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid_i,
  input  logic [1:0] cls_i,
  input  logic       pending_i,
  input  logic       ne_i,
  input  logic       ign_n_i,
  input  logic       irq_i,
  output logic       stall_o,
  output logic       pulse_o
);
  import fpx_pkg::*;

  logic frozen_r;
  logic pulse_r;
  logic waits;
  logic legacy_gate;

  assign waits       = valid_i && cls_waits(cls_i);
  assign legacy_gate = !ne_i && ign_n_i;
  assign stall_o     = waits && legacy_gate && (frozen_r || pending_i);

  always_ff @(posedge clk) begin
    if (!rst_n)        frozen_r <= 1'b0;
    else if (irq_i)    frozen_r <= 1'b0;
    else if (stall_o)  frozen_r <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_r <= 1'b0;
    else        pulse_r <= waits && ne_i && pending_i;
  end

  assign pulse_o = pulse_r;

  a_r4_nonwait_flows: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !cls_waits(cls_i)) |-> !stall_o);
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !irq_i) |=> (stall_o || !(waits && legacy_gate)));
  a_r9_pulse_origin: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> $past(ne_i && waits));
endmodule

// File: rtl/fpx_freeze_ctrl.sv
module fpx_freeze_ctrl #(
  parameter int NF = fpx_pkg::NFLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [1:0]    iss_cls,
  output logic          iss_ready,
  input  logic [NF-1:0] exc_set,
  input  logic [NF-1:0] exc_mask,
  input  logic          ne_mode,
  input  logic          ignerr_n,
  input  logic          irq_taken,
  input  logic          flag_clr,
  output logic          err_n,
  output logic          exc_pulse,
  output logic [NF-1:0] flags_q
);
  logic pending;
  logic stall;

  fpx_flag_bank #(.W(NF)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(exc_set), .mask_i(exc_mask),
    .clr_i(flag_clr), .flags_o(flags_q), .pending_o(pending)
  );

  fpx_freeze_unit u_frz (
    .clk(clk), .rst_n(rst_n), .valid_i(iss_valid), .cls_i(iss_cls),
    .pending_i(pending), .ne_i(ne_mode), .ign_n_i(ignerr_n),
    .irq_i(irq_taken), .stall_o(stall), .pulse_o(exc_pulse)
  );

  assign iss_ready = !stall;
  assign err_n     = !(pending && !ne_mode);

  a_r3_native_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ne_mode |-> err_n);
  a_r3_pin_needs_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !err_n |-> ((flags_q & ~exc_mask) != '0));
endmodule

// File: tb/sim_fpx_freeze_ctrl.sv
module sim_fpx_freeze_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic [1:0] iss_cls = 2'd0;
  logic iss_ready;
  logic [5:0] exc_set = '0;
  logic [5:0] exc_mask = '0;
  logic ne_mode = 1'b0;
  logic ignerr_n = 1'b1;
  logic irq_taken = 1'b0;
  logic flag_clr = 1'b0;
  logic err_n;
  logic exc_pulse;
  logic [5:0] flags_q;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fpx_freeze_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cls(iss_cls),
    .iss_ready(iss_ready), .exc_set(exc_set), .exc_mask(exc_mask),
    .ne_mode(ne_mode), .ignerr_n(ignerr_n), .irq_taken(irq_taken),
    .flag_clr(flag_clr), .err_n(err_n), .exc_pulse(exc_pulse), .flags_q(flags_q)
  );

  typedef struct packed {
    logic       v;
    logic [1:0] c;
    logic [5:0] s;
    logic [5:0] m;
    logic       ne;
    logic       ig;
    logic       irq;
    logic       clr;
    logic       e_rdy;
    logic       e_err;
    logic       e_pls;
    logic [5:0] e_flg;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{1'b1,2'd1,6'h00,6'h00,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,6'h00, 4'd5},  // R5 nothing pending
    '{1'b0,2'd0,6'h04,6'h00,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,6'h00, 4'd1},  // R1 set divide-by-zero
    '{1'b1,2'd0,6'h00,6'h00,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,6'h04, 4'd4},  // R4 non-FP flows
    '{1'b1,2'd2,6'h00,6'h00,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,6'h04, 4'd4},  // R4 no-wait flows
    '{1'b1,2'd1,6'h00,6'h00,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,6'h04, 4'd5},  // R5 waiting FP stalls
    '{1'b1,2'd1,6'h00,6'h04,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,6'h04, 4'd6},  // R6 masked, still frozen
    '{1'b1,2'd0,6'h00,6'h04,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,6'h04, 4'd4},  // R4 non-FP while frozen
    '{1'b1,2'd1,6'h00,6'h00,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,6'h04, 4'd6},  // R6 stall in irq cycle
    '{1'b1,2'd3,6'h00,6'h00,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,6'h04, 4'd7},  // R7 retrigger on WAIT
    '{1'b0,2'd0,6'h00,6'h00,1'b0,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0,6'h04, 4'd1},  // R1 clear issued
    '{1'b1,2'd1,6'h00,6'h00,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,6'h00, 4'd7},  // R7 cleared, issues
    '{1'b0,2'd0,6'h01,6'h00,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,6'h00, 4'd1},  // R1 set invalid
    '{1'b1,2'd3,6'h00,6'h00,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,6'h01, 4'd8},  // R8 ignore lets WAIT pass
    '{1'b1,2'd1,6'h00,6'h00,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,6'h01, 4'd9},  // R9 native: no stall
    '{1'b0,2'd0,6'h00,6'h00,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1,6'h01, 4'd9},  // R9 pulse next cycle
    '{1'b1,2'd0,6'h00,6'h00,1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,6'h01, 4'd9},  // R9 pulse one cycle
    '{1'b1,2'd1,6'h00,6'h01,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,6'h01, 4'd2},  // R2 masked, no stall
    '{1'b0,2'd0,6'h20,6'h00,1'b0,1'b1,1'b0,1'b1, 1'b1,1'b0,1'b0,6'h01, 4'd1},  // R1 set+clear together
    '{1'b0,2'd0,6'h00,6'h00,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,6'h20, 4'd1},  // R1 precision survives
    '{1'b0,2'd0,6'h00,6'h00,1'b0,1'b1,1'b0,1'b1, 1'b1,1'b0,1'b0,6'h20, 4'd1},  // R1 clear again
    '{1'b1,2'd3,6'h00,6'h00,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b0,6'h00, 4'd3}   // R3 pin released
  };

  task automatic check(input string rq, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {ready,err_n,pulse,flags} actual=%b expected=%b", rq, act, exp);
    end
  endtask

  task automatic idle();
    iss_valid = 0; iss_cls = 0; exc_set = 0; exc_mask = 0;
    ne_mode = 0; ignerr_n = 1; irq_taken = 0; flag_clr = 0;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    #4 check("R10", {iss_ready, err_n, exc_pulse, flags_q}, {1'b1, 1'b1, 1'b0, 6'h00});
    @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      iss_valid = TBL[i].v;  iss_cls = TBL[i].c;  exc_set = TBL[i].s;
      exc_mask = TBL[i].m;   ne_mode = TBL[i].ne; ignerr_n = TBL[i].ig;
      irq_taken = TBL[i].irq; flag_clr = TBL[i].clr;
      #4 check($sformatf("R%0d vec%0d", TBL[i].rq, i),
               {iss_ready, err_n, exc_pulse, flags_q},
               {TBL[i].e_rdy, TBL[i].e_err, TBL[i].e_pls, TBL[i].e_flg});
    end

    // R10: reset taken while frozen drops flags and freeze
    @(negedge clk); idle(); exc_set = 6'h08;
    @(negedge clk); idle(); iss_valid = 1; iss_cls = 2'd1;
    #4 check("R5 overflow stall", {iss_ready, err_n, exc_pulse, flags_q}, {1'b0, 1'b0, 1'b0, 6'h08});
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    #4 check("R10 reset while frozen", {iss_ready, err_n, exc_pulse, flags_q}, {1'b1, 1'b1, 1'b0, 6'h00});
    @(negedge clk); rst_n = 1;
    #4 check("R10 no freeze after reset", {iss_ready, err_n, exc_pulse, flags_q}, {1'b1, 1'b1, 1'b0, 6'h00});

    // R9: back-to-back waiting instructions in native mode pulse every cycle
    @(negedge clk); idle(); exc_set = 6'h10;
    @(negedge clk); idle(); ne_mode = 1; iss_valid = 1; iss_cls = 2'd3;
    @(negedge clk);
    #4 check("R9 pulse train", {iss_ready, err_n, exc_pulse, flags_q}, {1'b1, 1'b1, 1'b1, 6'h10});
    @(negedge clk); iss_valid = 0;
    #4 check("R9 pulse repeats", {iss_ready, err_n, exc_pulse, flags_q}, {1'b1, 1'b1, 1'b1, 6'h10});
    @(negedge clk);
    #4 check("R9 pulse ends", {iss_ready, err_n, exc_pulse, flags_q}, {1'b1, 1'b1, 1'b0, 6'h10});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule